// File: doc/BRIEF.md
# Trunk Egress Port Selector

This block sits after the address lookup of a 16-port switch. It turns the logical destination of each forwarded frame into the physical transmit port. Two link-aggregation groups can be configured. One is anchored at port 0 and grows upward. The other is anchored at port 15 and grows downward. When a frame is bound for any member of a group, the block picks exactly one member port.

The choice comes from a 2-bit hash. The hash is built from the ingress port number, from the source MAC address, or from the source and destination MAC addresses together, depending on a static balance mode. The hash is reduced modulo the group size and indexes the members in ascending port order. Traffic to a port outside any group passes through unchanged. A frame that entered on a member of its own destination group is not sent back into that group.

The result is a one-hot egress mask with a valid flag. Both are registered one clock after the frame strobe.

Top module: `trunk_egress_sel`

## Requirements
- R1: `egr_vld` equals the `frm_vld` value sampled at the previous rising clock edge, and `egr_mask` carries that frame's result in the same cycle. While reset is low, both outputs are zero.
- R2: A frame whose destination is in neither group produces a mask with only bit `dst_port` set.
- R3: Group A code `grp_a_code`: 0 means no group, 1 means ports 0–1, 2 means ports 0–2, 3 means ports 0–3 (size = code + 1).
- R4: Group B code `grp_b_code`: 0 means no group, 1 means ports 14–15, 2 means ports 13–15, 3 means ports 12–15.
- R5: In balance mode 0 (`bal_mode` = 2'b00), the hash is `src_port[1:0] ^ src_port[3:2]`.
- R6: In balance mode 1 (2'b01), the hash is the XOR of all 24 two-bit slices `src_mac[2i+1:2i]`.
- R7: In balance mode 2 (2'b10), the hash is the XOR of all 24 two-bit slices of `src_mac ^ dst_mac`.
- R8: Balance mode 3 (2'b11) selects exactly as mode 0.
- R9: For a destination inside a group of size N, the single mask bit set is member number (hash mod N), counting members from the lowest port number upward.
- R10: If the ingress port and the destination lie in the same group, the mask is all zero while `egr_vld` is still 1.
- R11: The mask has at most one bit set, and it is all zero in any cycle where `egr_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | Frame strobe, one cycle per frame |
| dst_port | input | 4 | Logical destination port from lookup |
| src_port | input | 4 | Ingress port number |
| src_mac | input | 48 | Source MAC address |
| dst_mac | input | 48 | Destination MAC address |
| grp_a_code | input | 2 | Size code for the group anchored at port 0 |
| grp_b_code | input | 2 | Size code for the group anchored at port 15 |
| bal_mode | input | 2 | Load-balance hash basis |
| egr_mask | output | 16 | One-hot physical egress mask |
| egr_vld | output | 1 | Result valid |

## Verification
The bench builds the block with its default parameters: 16 ports, 48-bit addresses and 2-bit group codes. At this size, every combination of the two group codes, the four balance modes, every destination port and every ingress port can be swept, which is 16,384 frames. Each frame carries a distinct address pair, so every group size is reached with all four hash residues in every mode. Each frame is followed by an idle cycle, which exposes the one-cycle latency and the zero mask between strobes.

// File: rtl/trunk_sel_pkg.sv
package trunk_sel_pkg;

    typedef enum logic [1:0] {
        BAL_INGRESS = 2'b00,
        BAL_SRC     = 2'b01,
        BAL_PAIR    = 2'b10,
        BAL_RSVD    = 2'b11
    } bal_mode_e;

endpackage

// File: rtl/trunk_fold.sv
module trunk_fold #(
    parameter int IN_W  = 48,
    parameter int OUT_W = 2
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int NSLICE = IN_W / OUT_W;

    always_comb begin
        dout = '0;
        for (int i = 0; i < NSLICE; i++) begin
            dout = dout ^ din[i*OUT_W +: OUT_W];
        end
    end

    initial begin
        assert_even_split_R6: assert (IN_W % OUT_W == 0)
            else $error("fold width %0d not a multiple of %0d", IN_W, OUT_W);
    end
endmodule

// File: rtl/trunk_group.sv
module trunk_group #(
    parameter int NPORT  = 16,
    parameter int CODE_W = 2,
    parameter bit HIGH   = 1'b0,
    localparam int PORT_W = $clog2(NPORT)
) (
    input  logic [CODE_W-1:0] code,
    input  logic [PORT_W-1:0] dst_port,
    input  logic [PORT_W-1:0] src_port,
    input  logic [CODE_W-1:0] hash,
    output logic [NPORT-1:0]  member_mask,
    output logic              dst_hit,
    output logic              src_hit,
    output logic [PORT_W-1:0] pick_port
);
    localparam int SZ_W = CODE_W + 1;

    logic [SZ_W-1:0]   size;
    logic [SZ_W-1:0]   idx;
    logic [PORT_W:0]   base;

    // Code 0 means no group; otherwise size is code + 1
    always_comb begin
        size = (code == '0) ? '0 : SZ_W'(code) + SZ_W'(1);
        base = HIGH ? ((PORT_W+1)'(NPORT) - (PORT_W+1)'(size)) : '0;
        idx  = (size == '0) ? '0 : ({1'b0, hash} % size);
        pick_port = PORT_W'(base + (PORT_W+1)'(idx));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_member
        if (HIGH) begin : g_hi
            assign member_mask[p] = ((PORT_W+1)'(p) >= base) && (size != '0);
        end else begin : g_lo
            assign member_mask[p] = ((SZ_W+PORT_W)'(p) < (SZ_W+PORT_W)'(size));
        end
    end

    assign dst_hit = member_mask[dst_port];
    assign src_hit = member_mask[src_port];

    always_comb begin
        if (dst_hit) begin
            assert_pick_in_group_R9: assert (member_mask[pick_port])
                else $error("picked port %0d outside group", pick_port);
        end
    end
endmodule

// File: rtl/trunk_egress_sel.sv
module trunk_egress_sel
    import trunk_sel_pkg::*;
#(
    parameter int NPORT  = 16,
    parameter int MAC_W  = 48,
    parameter int CODE_W = 2,
    localparam int PORT_W = $clog2(NPORT),
    localparam int NGRP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  logic [PORT_W-1:0] dst_port,
    input  logic [PORT_W-1:0] src_port,
    input  logic [MAC_W-1:0]  src_mac,
    input  logic [MAC_W-1:0]  dst_mac,
    input  logic [CODE_W-1:0] grp_a_code,
    input  logic [CODE_W-1:0] grp_b_code,
    input  logic [1:0]        bal_mode,
    output logic [NPORT-1:0]  egr_mask,
    output logic              egr_vld
);
    typedef struct packed {
        logic             vld;
        logic [NPORT-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0] h_ing, h_src, h_pair, hash;
    logic [MAC_W-1:0]  pair_key;

    assign pair_key = src_mac ^ dst_mac;

    trunk_fold #(.IN_W(PORT_W), .OUT_W(CODE_W)) u_fold_ing (
        .din(src_port), .dout(h_ing));
    trunk_fold #(.IN_W(MAC_W), .OUT_W(CODE_W)) u_fold_src (
        .din(src_mac), .dout(h_src));
    trunk_fold #(.IN_W(MAC_W), .OUT_W(CODE_W)) u_fold_pair (
        .din(pair_key), .dout(h_pair));

    always_comb begin
        case (bal_mode_e'(bal_mode))
            BAL_SRC:  hash = h_src;
            BAL_PAIR: hash = h_pair;
            default:  hash = h_ing;
        endcase
    end

    logic [NGRP-1:0][CODE_W-1:0] codes;
    logic [NGRP-1:0][NPORT-1:0]  mem_mask;
    logic [NGRP-1:0][PORT_W-1:0] pick;
    logic [NGRP-1:0]             dhit, shit;

    assign codes = {grp_b_code, grp_a_code};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        trunk_group #(.NPORT(NPORT), .CODE_W(CODE_W), .HIGH(g == 1)) u_grp (
            .code(codes[g]), .dst_port(dst_port), .src_port(src_port),
            .hash(hash), .member_mask(mem_mask[g]), .dst_hit(dhit[g]),
            .src_hit(shit[g]), .pick_port(pick[g]));
    end

    always_comb begin
        st_d      = '0;
        st_d.vld  = frm_vld;
        if (frm_vld) begin
            if ((dhit & shit) != '0) begin
                st_d.mask = '0;
            end else if (dhit[0]) begin
                st_d.mask[pick[0]] = 1'b1;
            end else if (dhit[1]) begin
                st_d.mask[pick[1]] = 1'b1;
            end else begin
                st_d.mask[dst_port] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign egr_mask = st_q.mask;
    assign egr_vld  = st_q.vld;

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.mask));
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld |-> (st_q.mask == '0));
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(frm_vld));
    assert_no_hairpin_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shit[0]) |-> ((st_q.mask & $past(mem_mask[0])) == '0));
    assert_no_hairpin_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shit[1]) |-> ((st_q.mask & $past(mem_mask[1])) == '0));
endmodule

// File: tb/test_trunk_egress_sel.sv
module test_trunk_egress_sel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_vld;
    logic [3:0]  dst_port, src_port;
    logic [47:0] src_mac, dst_mac;
    logic [1:0]  grp_a_code, grp_b_code, bal_mode;
    logic [15:0] egr_mask;
    logic        egr_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    trunk_egress_sel i_trunk_egress_sel (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .dst_port(dst_port),
        .src_port(src_port), .src_mac(src_mac), .dst_mac(dst_mac),
        .grp_a_code(grp_a_code), .grp_b_code(grp_b_code), .bal_mode(bal_mode),
        .egr_mask(egr_mask), .egr_vld(egr_vld));

    function automatic logic [1:0] fold48(input logic [47:0] v);
        logic [1:0] h = 2'b00;
        for (int i = 0; i < 24; i++) h ^= v[2*i +: 2];
        return h;
    endfunction

    function automatic logic [15:0] model(input int a, input int b, input int mode,
                                          input int d, input int s,
                                          input logic [47:0] sa, input logic [47:0] da);
        int sza, szb, h, idx, port;
        bit ina_d, inb_d, ina_s, inb_s;
        sza = (a == 0) ? 0 : a + 1;                 // R3
        szb = (b == 0) ? 0 : b + 1;                 // R4
        ina_d = d < sza;  ina_s = s < sza;
        inb_d = d >= 16 - szb;  inb_s = s >= 16 - szb;
        if ((ina_d && ina_s) || (inb_d && inb_s)) return 16'h0;   // R10
        case (mode)
            1: h = int'(fold48(sa));                // R6
            2: h = int'(fold48(sa ^ da));           // R7
            default: h = (s & 3) ^ ((s >> 2) & 3);  // R5, R8
        endcase
        if (ina_d) begin
            idx = h % sza; port = idx;              // R9
        end else if (inb_d) begin
            idx = h % szb; port = 16 - szb + idx;
        end else begin
            port = d;                               // R2
        end
        return 16'h1 << port;
    endfunction

    task automatic check(input string req, input logic [15:0] got_m, input logic [15:0] exp_m,
                         input logic got_v, input logic exp_v);
        n_tests++;
        if (got_m !== exp_m || got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: mask=%h vld=%b expected mask=%h vld=%b",
                     req, got_m, got_v, exp_m, exp_v);
        end
    endtask

    initial begin
        rst_n = 1'b0; frm_vld = 1'b0; dst_port = '0; src_port = '0;
        src_mac = '0; dst_mac = '0; grp_a_code = '0; grp_b_code = '0; bal_mode = '0;
        repeat (3) @(negedge clk);
        frm_vld = 1'b1;
        @(negedge clk);
        check("R1 reset", egr_mask, 16'h0, egr_vld, 1'b0);
        frm_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", egr_mask, 16'h0, egr_vld, 1'b0);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int d = 0; d < 16; d++) begin
                        for (int s = 0; s < 16; s++) begin
                            int k;
                            logic [47:0] sa, da;
                            logic [15:0] exp_m;
                            k  = (((a * 4 + b) * 4 + m) * 16 + d) * 16 + s;
                            sa = {16'hA5C3 ^ 16'(k), 32'(k) * 32'h9E3779B1};
                            da = {32'(k) * 32'h85EBCA6B, 16'h3C5A + 16'(k)};
                            exp_m = model(a, b, m, d, s, sa, da);
                            grp_a_code = 2'(a); grp_b_code = 2'(b); bal_mode = 2'(m);
                            dst_port = 4'(d); src_port = 4'(s);
                            src_mac = sa; dst_mac = da; frm_vld = 1'b1;
                            @(negedge clk);
                            check("R2/R3/R4/R5/R6/R7/R8/R9/R10 frame",
                                  egr_mask, exp_m, egr_vld, 1'b1);
                            frm_vld = 1'b0; dst_port = 4'(~d);
                            @(negedge clk);
                            if (s == 0) check("R11 idle gap", egr_mask, 16'h0, egr_vld, 1'b0);
                        end
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run incomplete, expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule